// File: doc/BRIEF.md
# Local Interrupt Winner Selector

This block picks the local interrupt that a hart should take next. It combines the pending and enable vectors into a candidate set. It then gates each candidate by the global enable of the privilege level that owns it. A delegation mask decides which candidates belong to the supervisor level and which stay with the machine level. Among the candidates that survive the gating, the lowest-numbered one wins. The block reports a valid flag and the winner's index.

The decision logic is purely combinational. A build parameter picks one of two output variants. The first is a register that loads every cycle and clears on a synchronous reset. The second is a direct path that answers in the same cycle as its inputs. Trap entry and status writes belong to the surrounding core. The privilege input is decoded into a named level: user, supervisor or machine. The reserved code is folded into the user level.

Top module: `irq_pick_top`

## Requirements
- R1: A bit is a candidate only when it is set in both the pending input and the enable input. A bit whose enable is clear is never reported.
- R2: Non-delegated candidates (delegation bit 0) are eligible when the privilege code is below machine (codes 0, 1 and 2). They are also eligible when the code is 3 (machine) and the machine global enable is 1.
- R3: Delegated candidates (delegation bit 1) are eligible when the privilege code is user (0). They are also eligible when the code is supervisor (1) and the supervisor global enable is 1. They are never eligible at machine level (3).
- R4: The eligible set is the union of the gated non-delegated and gated delegated candidates. A delegated bit is never reported while the level is machine.
- R5: When the eligible set is non-zero, the reported index is the position of its lowest set bit, and the valid flag is 1.
- R6: When the eligible set is empty, the valid flag is 0 and the index is 0.
- R7: Privilege code 2 behaves exactly like code 0 (user).
- R8: With REGISTERED=1, the outputs show the decision for the inputs sampled at the previous rising clock edge. They update on every edge.
- R9: With REGISTERED=1, a synchronous reset drives the valid flag to 0 and the index to 0 at the next edge, whatever the inputs are.
- R10: With REGISTERED=0, the outputs follow the inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | XLEN | Pending interrupt vector |
| en_i | input | XLEN | Interrupt enable vector |
| deleg_i | input | XLEN | Delegation mask; 1 hands the bit to the supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 2 treated as user, 3 machine |
| mie_i | input | 1 | Machine-level global interrupt enable |
| sie_i | input | 1 | Supervisor-level global interrupt enable |
| take_o | output | 1 | An eligible interrupt exists |
| take_idx_o | output | $clog2(XLEN) | Index of the winning interrupt, 0 when take_o is 0 |

## Verification
The bench builds two copies of the block side by side. The first uses XLEN=32 with REGISTERED=1, which covers the one-cycle latency, the reset clearing and winners up to bit 31. The second uses XLEN=16 with REGISTERED=0 and is fed the low half of the same stimulus. That copy checks the same-cycle path and the narrower index. Directed patterns cover every privilege code against both global enables and both delegation states. A stream of random vectors covers priority among several survivors.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_MACH  = 2'd3
    } lvl_e;

    function automatic lvl_e decode_lvl(input logic [1:0] code);
        lvl_e l;
        unique case (code)
            2'd1:    l = LVL_SUPER;
            2'd3:    l = LVL_MACH;
            default: l = LVL_USER;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
    import irq_pick_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] en_i,
    input  logic [XLEN-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            mie_i,
    input  logic            sie_i,
    output logic [XLEN-1:0] elig_o,
    output lvl_e            lvl_o
);

    logic [XLEN-1:0] cand;
    logic            mach_on;
    logic            sup_on;
    lvl_e            lvl;

    assign lvl  = decode_lvl(priv_i);
    assign cand = pend_i & en_i;

    always_comb begin
        unique case (lvl)
            LVL_USER: begin
                mach_on = 1'b1;
                sup_on  = 1'b1;
            end
            LVL_SUPER: begin
                mach_on = 1'b1;
                sup_on  = sie_i;
            end
            LVL_MACH: begin
                mach_on = mie_i;
                sup_on  = 1'b0;
            end
            default: begin
                mach_on = 1'b0;
                sup_on  = 1'b0;
            end
        endcase
    end

    assign elig_o = (cand & ~deleg_i & {XLEN{mach_on}})
                  | (cand &  deleg_i & {XLEN{sup_on}});
    assign lvl_o  = lvl;

endmodule

// File: rtl/irq_lsb_find.sv
module irq_lsb_find #(
    parameter int XLEN = 32,
    localparam int IW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] vec_i,
    output logic            hit_o,
    output logic [IW-1:0]   idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int b = XLEN - 1; b >= 0; b--) begin
            if (vec_i[b]) begin
                hit_o = 1'b1;
                idx_o = IW'(b);
            end
        end
    end

endmodule

// File: rtl/irq_pick_top.sv
module irq_pick_top
    import irq_pick_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter bit REGISTERED = 1'b1,
    localparam int IW        = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] en_i,
    input  logic [XLEN-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            mie_i,
    input  logic            sie_i,
    output logic            take_o,
    output logic [IW-1:0]   take_idx_o
);

    logic [XLEN-1:0] elig;
    lvl_e            lvl;
    logic            sel_hit;
    logic [IW-1:0]   sel_idx;

    irq_gate #(.XLEN(XLEN)) u_gate (
        .pend_i  (pend_i),
        .en_i    (en_i),
        .deleg_i (deleg_i),
        .priv_i  (priv_i),
        .mie_i   (mie_i),
        .sie_i   (sie_i),
        .elig_o  (elig),
        .lvl_o   (lvl)
    );

    irq_lsb_find #(.XLEN(XLEN)) u_find (
        .vec_i (elig),
        .hit_o (sel_hit),
        .idx_o (sel_idx)
    );

    generate
        if (REGISTERED) begin : g_reg
            logic          q_hit;
            logic [IW-1:0] q_idx;

            always_ff @(posedge clk) begin
                if (rst) begin
                    q_hit <= 1'b0;
                    q_idx <= '0;
                end else begin
                    q_hit <= sel_hit;
                    q_idx <= sel_idx;
                end
            end

            assign take_o     = q_hit;
            assign take_idx_o = q_idx;

            a_r8_latency: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (take_o == $past(sel_hit)) && (take_idx_o == $past(sel_idx)));
            a_r9_reset_clear: assert property (@(posedge clk)
                rst |=> !take_o && (take_idx_o == '0));
        end else begin : g_comb
            assign take_o     = sel_hit;
            assign take_idx_o = sel_idx;
        end
    endgenerate

    a_r1_cand_only: assert property (@(posedge clk) disable iff (rst)
        sel_hit |-> (pend_i[sel_idx] && en_i[sel_idx]));
    a_r4_no_deleg_in_mach: assert property (@(posedge clk) disable iff (rst)
        (sel_hit && lvl == LVL_MACH) |-> !deleg_i[sel_idx]);
    a_r5_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        sel_hit |-> ((elig & ((XLEN'(1) << sel_idx) - XLEN'(1))) == '0));
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !sel_hit |-> (sel_idx == '0) && (elig == '0));

endmodule

// File: tb/test_irq_pick_top.sv
module test_irq_pick_top;

    localparam int W  = 32;
    localparam int WN = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  pend = '0, en = '0, deleg = '0;
    logic [1:0]    priv = 2'd0;
    logic          mie = 1'b0, sie = 1'b0;
    logic          take_r, take_c;
    logic [4:0]    idx_r;
    logic [3:0]    idx_c;

    int checks = 0;
    int bad    = 0;

    typedef struct {
        logic       v;
        logic [4:0] i;
        string      tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    irq_pick_top #(.XLEN(W), .REGISTERED(1'b1)) i_irq_pick_top (
        .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .deleg_i(deleg),
        .priv_i(priv), .mie_i(mie), .sie_i(sie),
        .take_o(take_r), .take_idx_o(idx_r)
    );

    irq_pick_top #(.XLEN(WN), .REGISTERED(1'b0)) i_irq_pick_top_comb (
        .clk(clk), .rst(rst), .pend_i(pend[WN-1:0]), .en_i(en[WN-1:0]),
        .deleg_i(deleg[WN-1:0]), .priv_i(priv), .mie_i(mie), .sie_i(sie),
        .take_o(take_c), .take_idx_o(idx_c)
    );

    function automatic exp_t model(input int w, input string tag);
        exp_t e;
        logic m_ok, s_ok;
        m_ok = (priv != 2'd3) || mie;
        s_ok = (priv == 2'd0) || (priv == 2'd2) || (priv == 2'd1 && sie);
        e.v = 1'b0; e.i = '0; e.tag = tag;
        for (int b = 0; b < w; b++) begin
            if (!e.v && pend[b] && en[b] && (deleg[b] ? s_ok : m_ok)) begin
                e.v = 1'b1;
                e.i = 5'(b);
            end
        end
        return e;
    endfunction

    task automatic cmp(input string tag, input logic av, input logic [4:0] ai,
                       input logic ev, input logic [4:0] ei);
        checks++;
        if (av !== ev || ai !== ei) begin
            bad++;
            $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                     tag, av, ai, ev, ei);
        end
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp({e.tag, " reg"}, take_r, idx_r, e.v, e.i);
        end
    end

    task automatic drive(input logic [W-1:0] p, input logic [W-1:0] e,
                         input logic [W-1:0] d, input logic [1:0] pv,
                         input logic m, input logic s, input string tag);
        exp_t ec;
        @(negedge clk);
        #1;
        pend = p; en = e; deleg = d; priv = pv; mie = m; sie = s;
        q.push_back(model(W, tag));
        #1;
        ec = model(WN, tag);
        cmp({tag, " R10 comb"}, take_c, {1'b0, idx_c}, ec.v, ec.i);
    endtask

    initial begin
        #200000;
        bad++;
        checks++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp("R9 reset state", take_r, idx_r, 1'b0, 5'd0);
        @(negedge clk);
        rst = 1'b0;

        // R2: machine level, global enable on and off
        drive(32'h0000_0880, 32'hFFFF_FFFF, 32'h0, 2'd3, 1'b1, 1'b0, "R2 mach on");
        drive(32'h0000_0880, 32'hFFFF_FFFF, 32'h0, 2'd3, 1'b0, 1'b1, "R2 mach off");
        // R3/R4: delegated bits at machine level are blocked
        drive(32'h0000_0002, 32'hFFFF_FFFF, 32'h2, 2'd3, 1'b1, 1'b1, "R4 deleg in mach");
        drive(32'h0000_0022, 32'hFFFF_FFFF, 32'h2, 2'd3, 1'b1, 1'b1, "R4 mixed in mach");
        // R3: supervisor level
        drive(32'h0000_0002, 32'hFFFF_FFFF, 32'h2, 2'd1, 1'b0, 1'b0, "R3 super sie off");
        drive(32'h0000_0002, 32'hFFFF_FFFF, 32'h2, 2'd1, 1'b0, 1'b1, "R3 super sie on");
        drive(32'h0000_0200, 32'hFFFF_FFFF, 32'h2, 2'd1, 1'b0, 1'b0, "R2 nondeleg in super");
        // user level and reserved code
        drive(32'h0000_0006, 32'hFFFF_FFFF, 32'h2, 2'd0, 1'b0, 1'b0, "R3 user all");
        drive(32'h0000_0006, 32'hFFFF_FFFF, 32'h2, 2'd2, 1'b0, 1'b0, "R7 code2 as user");
        drive(32'h0000_4000, 32'hFFFF_FFFF, 32'h4000, 2'd2, 1'b0, 1'b0, "R7 code2 deleg");
        // R1: enable masks
        drive(32'h0000_00FF, 32'h0000_00F0, 32'h0, 2'd3, 1'b1, 1'b0, "R1 enable mask");
        drive(32'h0000_00FF, 32'h0000_FF00, 32'h0, 2'd3, 1'b1, 1'b0, "R1 disjoint");
        // R5: lowest wins, top bit
        drive(32'h8001_0100, 32'hFFFF_FFFF, 32'h0, 2'd0, 1'b0, 1'b0, "R5 lowest wins");
        drive(32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 2'd3, 1'b1, 1'b0, "R5 top bit");
        drive(32'h0000_0001, 32'h0000_0001, 32'h0, 2'd3, 1'b1, 1'b0, "R5 bit zero");
        // R6: nothing survives
        drive(32'h0, 32'hFFFF_FFFF, 32'h0, 2'd0, 1'b1, 1'b1, "R6 empty");

        // R8: random stream through the register
        for (int k = 0; k < 300; k++) begin
            drive($urandom, $urandom, $urandom, 2'($urandom),
                  1'($urandom), 1'($urandom), "R8 random");
        end

        // R9: reset clears even with a live winner
        drive(32'h0000_0010, 32'hFFFF_FFFF, 32'h0, 2'd0, 1'b0, 1'b0, "R8 pre-reset");
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        cmp("R9 sync reset", take_r, idx_r, 1'b0, 5'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule